// File: doc/BRIEF.md
# Processor Bus Cycle Strobe Generator

This block turns a requested bus cycle into the active-low control strobes of an 8-bit-data processor bus. A requester presents a cycle kind and an address. The block latches both when it is idle and walks the cycle through three T-states, T1, T2 and T3. It drives the memory request, I/O request, first-machine-cycle, read, write and refresh strobes in the combination that identifies the cycle kind. At the end of the cycle it pulses a completion flag.

Some cycle kinds share strobes, so the pairing tells them apart. An opcode fetch pairs the first-machine-cycle strobe with memory request. An acknowledge of the primary interrupt pairs it with I/O request. A refresh pairs the refresh strobe with memory request and places an internal 8-bit refresh counter on the low address byte. Each T-state lasts `2*HALF_CLKS` clocks, which lets the write strobe start half a T-state after memory request. A bus-release input drops the drive enable of the three-state outputs (address, memory request, I/O request, read, write). The first-machine-cycle and refresh strobes are always driven.

Top module: `bcyc_top`

## Requirements
- R1: An opcode fetch (kind 0) asserts the first-machine-cycle strobe (`m1_n`), memory request (`mreq_n`) and read (`rd_n`). I/O request, write and refresh stay high.
- R2: A memory read (kind 1) asserts memory request and read. A memory write (kind 2) asserts memory request and write. Read and write are never low together.
- R3: An I/O read (kind 3) asserts I/O request and read. An I/O write (kind 4) asserts I/O request and write. Memory request stays high for both.
- R4: A primary interrupt acknowledge (kind 5) asserts the first-machine-cycle strobe and I/O request together, with memory request, read, write and refresh high.
- R5: A secondary interrupt acknowledge (kind 6) asserts none of the six strobes, yet still runs three T-states and pulses `cyc_done`.
- R6: A refresh (kind 7) asserts refresh and memory request only. `addr_out[7:0]` then carries the refresh counter and `addr_out[15:8]` carries the requested address. The counter starts at 0 after reset, advances by one after each refresh cycle and wraps from 255 to 0.
- R7: A request seen on a rising edge while idle starts T1 on the next clock. With HALF_CLKS=1, strobes are low for the four clocks of T1 and T2. Write goes low one clock (half a T-state) after memory request. All strobes are high in T3. `cyc_done` is high only in the last clock of T3, the sixth clock.
- R8: Requests that arrive while a cycle is running are ignored. The running cycle keeps the strobes and address of the kind it latched.
- R9: While `bus_release` is high, `drv_en` is low in the same cycle. The sequencing, the first-machine-cycle and refresh strobes, and the refresh counter are unaffected.
- R10: For a non-refresh cycle, `addr_out` shows the requested address from T1 until the next request is accepted.
- R11: During reset all strobes are high, `cyc_done` is low and `addr_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state is 2*HALF_CLKS periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request, taken while idle |
| req_kind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write, 5 primary ack, 6 secondary ack, 7 refresh |
| req_addr | input | ADDR_W (16) | Address for the requested cycle |
| bus_release | input | 1 | Releases three-state outputs |
| addr_out | output | ADDR_W (16) | Address bus value |
| drv_en | output | 1 | Drive enable for address, mreq_n, iorq_n, rd_n, wr_n |
| m1_n | output | 1 | First-machine-cycle strobe, active low |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| cyc_done | output | 1 | One-clock completion pulse in the last clock of T3 |

## Verification
Two functions can act in the same cycle: the bus release and a refresh cycle that is advancing its counter. The bench raises `bus_release` in the middle of a refresh cycle. It checks that the drive enable falls while the refresh strobe stays low and the completion pulse still comes on the sixth clock. The next refresh must then show the counter one higher, so the release has neither frozen nor skipped the counter. A second overlap holds a different request valid through a running cycle, and the strobes must keep the first kind's pattern.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

   typedef enum logic [2:0] {
      CK_FETCH = 3'd0,
      CK_MRD   = 3'd1,
      CK_MWR   = 3'd2,
      CK_IORD  = 3'd3,
      CK_IOWR  = 3'd4,
      CK_IACK  = 3'd5,
      CK_IACK2 = 3'd6,
      CK_RFSH  = 3'd7
   } cyc_kind_e;

   typedef enum logic [1:0] {
      TS_IDLE = 2'd0,
      TS_T1   = 2'd1,
      TS_T2   = 2'd2,
      TS_T3   = 2'd3
   } tstate_e;

   // active-high view of the bus strobes
   typedef struct packed {
      logic m1;
      logic mreq;
      logic iorq;
      logic rd;
      logic wr;
      logic rfsh;
   } strobe_s;

endpackage

// File: rtl/bcyc_tseq.sv
module bcyc_tseq
   import bcyc_pkg::*;
#(
   parameter int HALF_CLKS = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   output tstate_e ts,
   output logic    late_half,
   output logic    last_clk
);

   localparam int TCLK = 2 * HALF_CLKS;
   localparam int PH_W = (TCLK > 2) ? $clog2(TCLK) : 1;

   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("HALF_CLKS must be at least 1");
      end
   endgenerate

   tstate_e           ts_q;
   logic [PH_W-1:0]   ph_q;
   logic              ph_end;

   assign ph_end    = (ph_q == PH_W'(TCLK - 1));
   assign late_half = (ph_q >= PH_W'(HALF_CLKS));
   assign last_clk  = (ts_q == TS_T3) && ph_end;
   assign ts        = ts_q;

   // phase counter variant chosen by the half-state length
   generate
      if (HALF_CLKS == 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 ph_q <= '0;
            else if (ts_q == TS_IDLE)   ph_q <= '0;
            else                        ph_q <= ~ph_q;
         end
      end else begin : g_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          ph_q <= '0;
            else if (ts_q == TS_IDLE || ph_end)  ph_q <= '0;
            else                                 ph_q <= ph_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_q <= TS_IDLE;
      end else begin
         unique case (ts_q)
            TS_IDLE: if (start)  ts_q <= TS_T1;
            TS_T1:   if (ph_end) ts_q <= TS_T2;
            TS_T2:   if (ph_end) ts_q <= TS_T3;
            TS_T3:   if (ph_end) ts_q <= TS_IDLE;
            default:             ts_q <= TS_IDLE;
         endcase
      end
   end

   // R7: phase counter rests at zero while idle
   a_r7_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_q == TS_IDLE) |-> (ph_q == '0));

   // R7: completion is a single-clock pulse followed by idle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      last_clk |=> (!last_clk && ts_q == TS_IDLE));

endmodule

// File: rtl/bcyc_decode.sv
module bcyc_decode
   import bcyc_pkg::*;
(
   input  cyc_kind_e kind,
   input  tstate_e   ts,
   input  logic      late_half,
   output strobe_s   act
);

   strobe_s base;
   logic    drive_phase;

   always_comb begin
      base = '0;
      case (kind)
         CK_FETCH: begin base.m1 = 1'b1; base.mreq = 1'b1; base.rd = 1'b1; end
         CK_MRD:   begin base.mreq = 1'b1; base.rd = 1'b1; end
         CK_MWR:   begin base.mreq = 1'b1; base.wr = 1'b1; end
         CK_IORD:  begin base.iorq = 1'b1; base.rd = 1'b1; end
         CK_IOWR:  begin base.iorq = 1'b1; base.wr = 1'b1; end
         CK_IACK:  begin base.m1 = 1'b1; base.iorq = 1'b1; end
         CK_IACK2: base = '0;
         CK_RFSH:  begin base.rfsh = 1'b1; base.mreq = 1'b1; end
         default:  base = '0;
      endcase
   end

   assign drive_phase = (ts == TS_T1) || (ts == TS_T2);

   always_comb begin
      act    = drive_phase ? base : '0;
      // write waits for the second half of T1
      act.wr = base.wr && ((ts == TS_T2) || ((ts == TS_T1) && late_half));
   end

endmodule

// File: rtl/bcyc_rfcnt.sv
module bcyc_rfcnt #(
   parameter int RF_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   output logic [RF_W-1:0] cnt
);

   generate
      if (RF_W < 1) begin : g_bad_w
         $error("RF_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   // R6: one step per refresh, wrapping modulo 2**RF_W
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> (cnt == RF_W'($past(cnt) + 1'b1)));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));

endmodule

// File: rtl/bcyc_top.sv
module bcyc_top
   import bcyc_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int RF_W      = 8,
   parameter int HALF_CLKS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              bus_release,
   output logic [ADDR_W-1:0] addr_out,
   output logic              drv_en,
   output logic              m1_n,
   output logic              mreq_n,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              rfsh_n,
   output logic              cyc_done
);

   generate
      if (RF_W > ADDR_W) begin : g_bad_rf
         $error("RF_W may not exceed ADDR_W");
      end
   endgenerate

   tstate_e           ts;
   logic              late_half;
   logic              last_clk;
   logic              start;
   cyc_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [RF_W-1:0]   rcnt;
   strobe_s           act;

   assign start = req_valid && (ts == TS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= CK_FETCH;
         addr_q <= '0;
      end else if (start) begin
         kind_q <= cyc_kind_e'(req_kind);
         addr_q <= req_addr;
      end
   end

   bcyc_tseq #(.HALF_CLKS(HALF_CLKS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ts        (ts),
      .late_half (late_half),
      .last_clk  (last_clk)
   );

   bcyc_decode u_dec (
      .kind      (kind_q),
      .ts        (ts),
      .late_half (late_half),
      .act       (act)
   );

   bcyc_rfcnt #(.RF_W(RF_W)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (last_clk && (kind_q == CK_RFSH)),
      .cnt   (rcnt)
   );

   // refresh counter replaces the low address bits
   generate
      if (RF_W == ADDR_W) begin : g_full_rf
         assign addr_out = (kind_q == CK_RFSH) ? rcnt : addr_q;
      end else begin : g_part_rf
         assign addr_out = (kind_q == CK_RFSH) ? {addr_q[ADDR_W-1:RF_W], rcnt} : addr_q;
      end
   endgenerate

   assign m1_n     = ~act.m1;
   assign mreq_n   = ~act.mreq;
   assign iorq_n   = ~act.iorq;
   assign rd_n     = ~act.rd;
   assign wr_n     = ~act.wr;
   assign rfsh_n   = ~act.rfsh;
   assign drv_en   = ~bus_release;
   assign cyc_done = last_clk;

   // R1/R4: first-machine-cycle pairs with exactly one request strobe
   a_r1_m1_pair: assert property (@(posedge clk) disable iff (!rst_n)
      !m1_n |-> (mreq_n != iorq_n));

   // R6: refresh only ever alongside memory request
   a_r6_rfsh_mreq: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> (!mreq_n && m1_n && rd_n && wr_n));

   // R2: read and write exclusive
   a_r2_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R7: write falls only after memory or I/O request was already low
   a_r7_wr_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> ($past(!mreq_n) || $past(!iorq_n)));

   // R8: latched kind cannot change while a cycle runs
   a_r8_kind_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ts != TS_IDLE) |=> $stable(kind_q));

endmodule

// File: tb/sim_bcyc_top.sv
module sim_bcyc_top;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_kind = 3'd0;
   logic [AW-1:0] req_addr = '0;
   logic          bus_release = 1'b0;
   logic [AW-1:0] addr_out;
   logic          drv_en, m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n, cyc_done;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] rmodel = 8'd0;
   bit finished = 1'b0;

   always #2ns clk = ~clk;

   bcyc_top #(.ADDR_W(AW), .RF_W(8), .HALF_CLKS(1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .bus_release(bus_release), .addr_out(addr_out),
      .drv_en(drv_en), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
      .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .cyc_done(cyc_done)
   );

   // vector: kind[24:22], addr[21:6], active mask {m1,mreq,iorq,rd,wr,rfsh}[5:0]
   localparam int NV = 10;
   localparam logic [24:0] VEC [NV] = '{
      {3'd0, 16'h1234, 6'b110100},   // R1 fetch
      {3'd1, 16'h8001, 6'b010100},   // R2 mem read
      {3'd2, 16'hFFFE, 6'b010010},   // R2 mem write
      {3'd3, 16'h00A5, 6'b001100},   // R3 io read
      {3'd4, 16'h5A00, 6'b001010},   // R3 io write
      {3'd5, 16'h0038, 6'b101000},   // R4 primary ack
      {3'd6, 16'h0066, 6'b000000},   // R5 secondary ack
      {3'd7, 16'hC3FF, 6'b010001},   // R6 refresh
      {3'd7, 16'h3C00, 6'b010001},   // R6 refresh again
      {3'd1, 16'h0000, 6'b010100}    // R10 mem read
   };

   function automatic string rname(input logic [2:0] k);
      case (k)
         3'd0: return "R1";
         3'd1, 3'd2: return "R2";
         3'd3, 3'd4: return "R3";
         3'd5: return "R4";
         3'd6: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   function automatic logic [5:0] strobes();
      return {m1_n, mreq_n, iorq_n, rd_n, wr_n, rfsh_n};
   endfunction

   // one full cycle; checks every clock from T1 to the idle clock after
   task automatic run_cycle(input logic [2:0] k, input logic [AW-1:0] a,
                            input logic [5:0] mask, input bit hold_other,
                            input bit rel_mid, input bit quiet);
      logic [AW-1:0] ea;
      string rq;
      rq = rname(k);
      ea = (k == 3'd7) ? {a[15:8], rmodel} : a;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a;
      for (int c = 1; c <= 7; c++) begin
         @(negedge clk);
         if (c == 1) begin
            if (hold_other) begin req_kind = ~k; req_addr = ~a; end
            else req_valid = 1'b0;
         end
         if (c == 5) req_valid = 1'b0;
         if (rel_mid && c == 2) bus_release = 1'b1;
         if (!quiet) begin
            if (c == 1)
               chk(hold_other ? "R8" : "R7", "strobes T1a", {26'd0, strobes()},
                   {26'd0, ~(mask & 6'b111101)});
            else if (c <= 4)
               chk(hold_other ? "R8" : rq, "strobes T1b/T2", {26'd0, strobes()},
                   {26'd0, ~mask});
            else
               chk("R7", "strobes T3/idle", {26'd0, strobes()}, 32'h3F);
            chk("R7", "cyc_done", {31'd0, cyc_done}, {31'd0, c == 6});
         end
         if (c <= 4 && (!quiet || k == 3'd7))
            chk(k == 3'd7 ? "R6" : "R10", "addr", {16'd0, addr_out}, {16'd0, ea});
         if (rel_mid && c == 3) begin
            chk("R9", "drv_en released", {31'd0, drv_en}, 32'd0);
            chk("R9", "rfsh_n kept", {31'd0, rfsh_n}, 32'd0);
         end
         if (rel_mid && c == 5) bus_release = 1'b0;
      end
      if (k == 3'd7) rmodel = rmodel + 8'd1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "strobes in reset", {26'd0, strobes()}, 32'h3F);
      chk("R11", "done in reset", {31'd0, cyc_done}, 32'd0);
      chk("R11", "addr in reset", {16'd0, addr_out}, 32'd0);
      bus_release = 1'b1;
      #0.1ns;
      chk("R9", "drv_en low", {31'd0, drv_en}, 32'd0);
      bus_release = 1'b0;
      #0.1ns;
      chk("R9", "drv_en high", {31'd0, drv_en}, 32'd1);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         run_cycle(VEC[i][24:22], VEC[i][21:6], VEC[i][5:0], 1'b0, 1'b0, 1'b0);

      // R8: a different request held through a fetch
      run_cycle(3'd0, 16'h4321, 6'b110100, 1'b1, 1'b0, 1'b0);
      chk("R8", "addr kept after ignored req", {16'd0, addr_out}, 32'h4321);

      // R9: release during a refresh, then the counter must still step
      run_cycle(3'd7, 16'hAA00, 6'b010001, 1'b0, 1'b1, 1'b0);
      run_cycle(3'd7, 16'h5500, 6'b010001, 1'b0, 1'b0, 1'b0);

      // R6: run the counter past its wrap
      for (int j = 0; j < 260; j++)
         run_cycle(3'd7, 16'h7700, 6'b010001, 1'b0, 1'b0, 1'b1);
      run_cycle(3'd7, 16'h0100, 6'b010001, 1'b0, 1'b0, 1'b0);

      // R2: write following memory request by half a T-state
      run_cycle(3'd2, 16'h0F0F, 6'b010010, 1'b0, 1'b0, 1'b0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R7 watchdog: actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule